// File: doc/BRIEF.md
# Short-Displacement Load/Store Unit

This unit executes the compact load and store forms that address memory at a small unsigned offset from a fixed base, which is general register 30. It takes the access size, the direction, a 7-bit displacement field, the value of register 30, the store data and the destination register index. From these it forms the effective address and the byte enables, and issues one request on a simple synchronous memory port. When load data comes back it formats the data and writes it to the register file.

The displacement is unsigned and scaled by the access size. For a word access, bit 0 of the field is discarded before scaling, so halfword and word offsets use the same field layout. Memory is little-endian. Lane 0 of the data bus carries bits 7:0. The unit handles one operation at a time and reports busy from the moment it accepts a request until the memory response returns.

Top module: `lsu_short_disp`

## Requirements
- R1: The effective address `mem_addr` is `base_r30 + offset`, where offset is the scaled, zero-extended displacement.
- R2: For size code 2'b00 (byte), the offset is the 7-bit field zero-extended and not scaled (0..127).
- R3: For size code 2'b01 (halfword), the offset is the zero-extended field shifted left by one (0..254).
- R4: For size codes 2'b10 and 2'b11 (word), the offset is the field with bit 0 cleared, then shifted left by one. This gives a word-aligned offset of at most 252.
- R5: `mem_be` is the size mask (byte 4'b0001, halfword 4'b0011, word 4'b1111) shifted left by `mem_addr[1:0]`. `mem_wdata` is the store data shifted left by 8*`mem_addr[1:0]`, so a store writes only the low 1, 2 or 4 bytes of the source. `mem_we` is 1 for stores and 0 for loads.
- R6: A byte load takes the byte in lane `mem_addr[1:0]` and sign-extends it to 32 bits.
- R7: A halfword load takes the 16 bits starting at lane `mem_addr[1:0]` and sign-extends them. A word load is written back unchanged.
- R8: `mem_req_valid` rises on the cycle after acceptance. It stays high, with address, enables, data and direction stable, until a cycle in which `mem_req_ready` is high.
- R9: `busy` is high from acceptance until the cycle after `mem_rsp_valid`. `req_ready` is its inverse. A `req_valid` seen while busy is ignored.
- R10: For a load, `wb_en` is high for exactly one cycle, the cycle after `mem_rsp_valid`, with `wb_idx` equal to the accepted destination index. A store never raises `wb_en`.
- R11: During and after reset, `busy`, `mem_req_valid` and `wb_en` are 0 and `req_ready` is 1. A reset in the middle of an operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_disp | input | 7 | Unsigned displacement field |
| base_r30 | input | 32 | Value of register 30 |
| req_wdata | input | 32 | Store source register value |
| req_rd | input | 5 | Load destination register index |
| busy | output | 1 | Operation in flight |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rdata | input | 32 | Aligned read word |
| wb_en | output | 1 | Register write enable |
| wb_idx | output | 5 | Register write index |
| wb_data | output | 32 | Register write data |

## Verification
The checks assume that `base_r30` is aligned to the access size, so no access crosses a word boundary. They also assume that the memory raises `mem_rsp_valid` only while the unit waits for a response. The stimulus uses bases that are multiples of 4 and sends each response only after the request has been taken. The unsupported-but-legal cases are still driven: requests while busy, and stalls with `mem_req_ready` held low.

// File: rtl/lsu_sd_pkg.sv
package lsu_sd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_sd_addr.sv
module lsu_sd_addr
  import lsu_sd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 7
) (
  input  logic [1:0]        size,
  input  logic [DISP_W-1:0] disp,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   addr,
  output logic [XLEN/8-1:0] be,
  output logic [XLEN-1:0]   lane_wdata
);
  localparam int LANES = XLEN / 8;
  localparam int LW    = $clog2(LANES);

  function automatic logic [XLEN-1:0] scaled_offset(input logic [1:0] sz,
                                                     input logic [DISP_W-1:0] d);
    logic [XLEN-1:0] z;
    z = XLEN'(d);
    case (acc_size_e'(sz))
      SZ_BYTE: return z;
      SZ_HALF: return z << 1;
      default: return (z & ~XLEN'(1)) << 1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] size_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return LANES'(4'b0001);
      SZ_HALF: return LANES'(4'b0011);
      default: return LANES'(4'b1111);
    endcase
  endfunction

  logic [LW-1:0] lane;

  always_comb begin
    addr       = base + scaled_offset(size, disp);
    lane       = addr[LW-1:0];
    be         = size_mask(size) << lane;
    lane_wdata = wdata << {lane, 3'b000};
  end
endmodule

// File: rtl/lsu_sd_load_fmt.sv
module lsu_sd_load_fmt
  import lsu_sd_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]               size,
  input  logic [$clog2(XLEN/8)-1:0] lane,
  input  logic [XLEN-1:0]          rdata,
  output logic [XLEN-1:0]          value
);
  function automatic logic [XLEN-1:0] extend(input logic [1:0] sz,
                                             input logic [XLEN-1:0] s);
    case (acc_size_e'(sz))
      SZ_BYTE: return {{(XLEN-8){s[7]}}, s[7:0]};
      SZ_HALF: return {{(XLEN-16){s[15]}}, s[15:0]};
      default: return s;
    endcase
  endfunction

  logic [XLEN-1:0] shifted;

  always_comb begin
    shifted = rdata >> {lane, 3'b000};
    value   = extend(size, shifted);
  end
endmodule

// File: rtl/lsu_sd_ctrl.sv
module lsu_sd_ctrl
  import lsu_sd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  output logic       accept,
  output logic       issuing,
  output logic       rsp_take,
  output logic       busy
);
  lsu_state_e st, st_nx;

  always_comb begin
    accept   = (st == ST_IDLE) && req_valid;
    issuing  = (st == ST_ISSUE);
    rsp_take = (st == ST_WAIT) && mem_rsp_valid;
    busy     = (st != ST_IDLE);
    st_nx    = st;
    case (st)
      ST_IDLE:  if (req_valid)     st_nx = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) st_nx = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) st_nx = ST_IDLE;
      default:                     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end
endmodule

// File: rtl/lsu_short_disp.sv
module lsu_short_disp
  import lsu_sd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 7,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [DISP_W-1:0] req_disp,
  input  logic [XLEN-1:0]   base_r30,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [RIDX_W-1:0] req_rd,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [XLEN/8-1:0] mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              wb_en,
  output logic [RIDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  localparam int LANES = XLEN / 8;
  localparam int LW    = $clog2(LANES);

  logic              accept, issuing, rsp_take;
  logic [XLEN-1:0]   ea, lane_wd, ld_value;
  logic [LANES-1:0]  be_c;
  logic [1:0]        size_q;
  logic              store_q;
  logic [RIDX_W-1:0] rd_q;

  lsu_sd_ctrl u_ctrl (
    .clk, .rst_n, .req_valid, .mem_req_ready, .mem_rsp_valid,
    .accept, .issuing, .rsp_take, .busy
  );

  lsu_sd_addr #(.XLEN(XLEN), .DISP_W(DISP_W)) u_addr (
    .size(req_size), .disp(req_disp), .base(base_r30), .wdata(req_wdata),
    .addr(ea), .be(be_c), .lane_wdata(lane_wd)
  );

  lsu_sd_load_fmt #(.XLEN(XLEN)) u_fmt (
    .size(size_q), .lane(mem_addr[LW-1:0]), .rdata(mem_rdata), .value(ld_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      store_q   <= 1'b0;
      size_q    <= 2'b00;
      rd_q      <= '0;
    end else if (accept) begin
      mem_addr  <= ea;
      mem_be    <= be_c;
      mem_wdata <= lane_wd;
      store_q   <= req_store;
      size_q    <= req_size;
      rd_q      <= req_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_en <= rsp_take && !store_q;
      if (rsp_take && !store_q) begin
        wb_idx  <= rd_q;
        wb_data <= ld_value;
      end
    end
  end

  assign mem_req_valid = issuing;
  assign mem_we        = store_q;
  assign req_ready     = !busy;
endmodule

// File: rtl/lsu_short_disp_chk.sv
module lsu_short_disp_chk #(
  parameter int XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              req_ready,
  input logic              accept,
  input logic              rsp_take,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_we,
  input logic [XLEN-1:0]   mem_addr,
  input logic [XLEN/8-1:0] mem_be,
  input logic [XLEN-1:0]   mem_wdata,
  input logic              wb_en
);
  localparam int LW = $clog2(XLEN/8);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_be) && $stable(mem_wdata) && $stable(mem_we));

  p_busy_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy && !req_ready);

  p_no_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  p_wb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);

  p_wb_after_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_en) |-> $past(rsp_take) && !$past(mem_we));

  p_be_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                       || $countones(mem_be) == 4));

  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (mem_be == '1) |-> mem_addr[LW-1:0] == '0);
endmodule

bind lsu_short_disp lsu_short_disp_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .req_ready(req_ready),
  .accept(accept), .rsp_take(rsp_take), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .wb_en(wb_en)
);

// File: tb/sim_lsu_short_disp.sv
`timescale 1ns/1ps
module sim_lsu_short_disp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [6:0]  req_disp = '0;
  logic [31:0] base_r30 = '0, req_wdata = '0, mem_rdata = '0;
  logic [4:0]  req_rd = '0;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic        req_ready, busy, mem_req_valid, mem_we, wb_en;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0]  mem_be;
  logic [4:0]  wb_idx;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  lsu_short_disp u0 (.*);

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic [6:0]  disp;
    logic [31:0] base;
    logic [31:0] wd;
    logic [31:0] rdat;
    logic [31:0] eaddr;
    logic [3:0]  ebe;
    logic [31:0] ewd;
    logic [31:0] ewb;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t V [NV] = '{
    '{1'b0, 2'd0, 7'h05, 32'h1000, 32'h0, 32'h0000_8000, 32'h1005, 4'b0010, 32'h0, 32'hFFFF_FF80},
    '{1'b0, 2'd0, 7'h7F, 32'h2000, 32'h0, 32'h7F00_0000, 32'h207F, 4'b1000, 32'h0, 32'h0000_007F},
    '{1'b0, 2'd1, 7'h03, 32'h3000, 32'h0, 32'h9ABC_0000, 32'h3006, 4'b1100, 32'h0, 32'hFFFF_9ABC},
    '{1'b0, 2'd1, 7'h7F, 32'h0000, 32'h0, 32'h1234_5678, 32'h00FE, 4'b1100, 32'h0, 32'h0000_1234},
    '{1'b0, 2'd2, 7'h7F, 32'h4000, 32'h0, 32'h8765_4321, 32'h40FC, 4'b1111, 32'h0, 32'h8765_4321},
    '{1'b0, 2'd2, 7'h01, 32'h5000, 32'h0, 32'h0000_00A5, 32'h5000, 4'b1111, 32'h0, 32'h0000_00A5},
    '{1'b1, 2'd0, 7'h02, 32'h6000, 32'hAABB_CCDD, 32'h0, 32'h6002, 4'b0100, 32'hCCDD_0000, 32'h0},
    '{1'b1, 2'd1, 7'h01, 32'h7000, 32'h1122_3344, 32'h0, 32'h7002, 4'b1100, 32'h3344_0000, 32'h0},
    '{1'b1, 2'd2, 7'h11, 32'h8000, 32'hDEAD_BEEF, 32'h0, 32'h8020, 4'b1111, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 2'd3, 7'h03, 32'h0100, 32'h0, 32'h0000_0055, 32'h0104, 4'b1111, 32'h0, 32'h0000_0055}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int i, input bit stall);
    vec_t v = V[i];
    @(negedge clk);
    req_valid = 1'b1; req_store = v.st; req_size = v.sz; req_disp = v.disp;
    base_r30 = v.base; req_wdata = v.wd; req_rd = 5'(i + 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk($sformatf("R8 v%0d req valid", i), 32'(mem_req_valid), 32'd1);
    chk($sformatf("R1 R2 R3 R4 v%0d addr", i), mem_addr, v.eaddr);
    chk($sformatf("R5 v%0d be", i), 32'(mem_be), 32'(v.ebe));
    chk($sformatf("R5 v%0d we", i), 32'(mem_we), 32'(v.st));
    if (v.st) chk($sformatf("R5 v%0d wdata", i), mem_wdata, v.ewd);
    if (stall) begin
      base_r30 = 32'hFFFF_0000; req_disp = 7'h55;
      @(negedge clk);
      chk($sformatf("R8 v%0d held valid", i), 32'(mem_req_valid), 32'd1);
      chk($sformatf("R8 v%0d held addr", i), mem_addr, v.eaddr);
      chk($sformatf("R9 v%0d req_ready low", i), 32'(req_ready), 32'd0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk($sformatf("R8 v%0d valid dropped", i), 32'(mem_req_valid), 32'd0);
    req_valid = 1'b1; req_rd = 5'h1F; req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk($sformatf("R9 v%0d busy ignores req", i), 32'(mem_req_valid), 32'd0);
    mem_rsp_valid = 1'b1; mem_rdata = v.rdat;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk($sformatf("R10 v%0d wb_en", i), 32'(wb_en), 32'(!v.st));
    chk($sformatf("R9 v%0d busy cleared", i), 32'(busy), 32'd0);
    if (!v.st) begin
      chk($sformatf("R6 R7 v%0d wb_data", i), wb_data, v.ewb);
      chk($sformatf("R10 v%0d wb_idx", i), 32'(wb_idx), 32'(i + 1));
    end
    @(negedge clk);
    chk($sformatf("R10 v%0d wb single pulse", i), 32'(wb_en), 32'd0);
    chk($sformatf("R9 v%0d no ghost request", i), 32'(mem_req_valid), 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 busy in reset", 32'(busy), 32'd0);
    chk("R11 req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    chk("R11 wb_en after reset", 32'(wb_en), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(i, (i % 3) == 1);

    // R11: reset in the middle of an operation abandons it
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b0; req_size = 2'd2; req_disp = 7'h04;
    base_r30 = 32'h9000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 mid-op request issued", 32'(mem_req_valid), 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R11 mid-op reset clears valid", 32'(mem_req_valid), 32'd0);
    chk("R11 mid-op reset clears busy", 32'(busy), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after mid-op reset", 32'(req_ready), 32'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule